// File: doc/BRIEF.md
# Vector-Priority Interrupt Acceptance Unit

This block sits beside one processor core and decides which interrupt the core takes next. Interrupt messages arrive as an 8-bit vector. They join a pending bitmap, and the unit offers the core the highest pending vector that clears two thresholds: the task-priority class written by software, and the class of the highest vector the core is already servicing. The class of a vector is its upper four bits. Only the vector number sets priority; the line or message a request came in on plays no part. When the core acknowledges, the offered vector moves from pending to in-service. A write to the end-of-interrupt register later retires the highest in-service vector. If the core acknowledges while nothing is eligible, it receives the programmable spurious vector and nothing changes state.

Three local lines and one internal source each have a configuration entry. The lines are a timer tick and two general local inputs; the internal source is the error logger. Each entry holds a vector, a delivery mode, a trigger select and a mask. A global software enable gates all delivery. Received vectors below 16 are illegal: the unit drops them and logs them in an error accumulator. Software sees the accumulated errors only after a write to the error status register latches them.

Software reaches the unit through a flat 32-bit register port with single-cycle writes and combinational reads.

Top module: `vec_irq_core`

## Requirements
- R1: After reset every local entry reads 0x0001_0000 (mask bit 16 set), task priority reads 0, the enable/spurious register reads 0x0FF (bit 8 enable = 0, bits 7:0 = 0xFF), the format register reads 0xFFFF_FFFF, error status reads 0, and `irq_req` is low.
- R2: With bit 8 of the register at 0x0F0 clear, `irq_req` and `ext_intr` stay low and `irq_vector` shows the spurious vector in bits 7:0. Messages received meanwhile stay pending and are offered once the bit is set.
- R3: Of several pending vectors, the numerically highest is offered on `irq_vector`.
- R4: A pending vector is offered only if its bits 7:4 are strictly greater than bits 7:4 of the task-priority register at 0x080.
- R5: A pending vector is offered only if its bits 7:4 are strictly greater than the class of the highest in-service vector.
- R6: When `irq_ack` is high while `irq_req` is high, the next cycle has `ack_valid` high with `ack_vector` equal to the offered vector, and that vector leaves the pending set.
- R7: When `irq_ack` is high while `irq_req` is low, `ack_vector` returns the spurious vector and no in-service bit is set.
- R8: Any write to offset 0x0B0 clears only the highest set in-service bit.
- R9: A message with vector below 16 is dropped and sets bit 6 of the error accumulator. A write of any data to 0x280 copies the accumulator into the readable status and clears the accumulator; the status is 0 until then.
- R10: Each error logged raises an edge on the error source, which pends the vector of the error entry at 0x370 when that entry is unmasked.
- R11: For the general local inputs (entries 0x350, 0x360) in fixed mode (bits 10:8 = 000): a set mask (bit 16) blocks the line. With bit 15 = 0, each rising edge pends the vector once. With bit 15 = 1, a high line re-pends the vector whenever it is not in service.
- R12: In external mode (bits 10:8 = 111), an unmasked local input drives `ext_intr` while high and pends nothing.
- R13: The timer entry at 0x320 and the error entry are always edge-triggered, whatever bit 15 holds.
- R14: The format register at 0x0E0 stores bits 31:28 as written. Bits 27:0 read as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| msg_valid | input | 1 | Interrupt message present this cycle |
| msg_vector | input | 8 | Vector carried by the message |
| timer_tick | input | 1 | Timer source line |
| local_in0 | input | 1 | General local input 0 (entry 0x350) |
| local_in1 | input | 1 | General local input 1 (entry 0x360) |
| irq_req | output | 1 | An eligible vector is offered |
| irq_vector | output | 8 | Offered vector, or spurious vector when none |
| irq_ack | input | 1 | Core acknowledge |
| ack_valid | output | 1 | Acknowledge result valid (one cycle) |
| ack_vector | output | 8 | Vector handed to the core by the acknowledge |
| ext_intr | output | 1 | Request for an externally supplied vector |

## Verification
A pending or in-service bitmap gone wrong shows up at once on `irq_vector`/`irq_req`. The offered vector is a combinational view of those registers, so a lost pending bit or a stray in-service bit is visible in the cycle after the edge that caused it. Stray in-service state is the subtler fault. It only blocks lower classes, so the scenarios follow each acknowledge or retire with a lower-class request and watch whether it is offered. A wrong error accumulator is invisible until the next status write. The bench therefore reads the status both before and after a latch write.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam logic [11:0] OFS_TPR     = 12'h080;
   localparam logic [11:0] OFS_EOI     = 12'h0B0;
   localparam logic [11:0] OFS_DFR     = 12'h0E0;
   localparam logic [11:0] OFS_SVR     = 12'h0F0;
   localparam logic [11:0] OFS_ESR     = 12'h280;
   localparam logic [11:0] OFS_LVT_TMR = 12'h320;
   localparam logic [11:0] OFS_LVT_L0  = 12'h350;
   localparam logic [11:0] OFS_LVT_L1  = 12'h360;
   localparam logic [11:0] OFS_LVT_ERR = 12'h370;

   localparam int SRC_TMR = 0;
   localparam int SRC_L0  = 1;
   localparam int SRC_L1  = 2;
   localparam int SRC_ERR = 3;
   localparam int NUM_SRC = 4;

   localparam logic [2:0] DM_EXT  = 3'b111;
   localparam int ERR_RX_BIT      = 6;

   typedef struct packed {
      logic       mask;
      logic       level;
      logic [2:0] mode;
      logic [7:0] vec;
   } lvt_t;

   localparam lvt_t LVT_RESET = '{mask: 1'b1, level: 1'b0, mode: 3'b000, vec: 8'h00};

   function automatic logic [11:0] lvt_offset(input int s);
      case (s)
         SRC_TMR: lvt_offset = OFS_LVT_TMR;
         SRC_L0:  lvt_offset = OFS_LVT_L0;
         SRC_L1:  lvt_offset = OFS_LVT_L1;
         default: lvt_offset = OFS_LVT_ERR;
      endcase
   endfunction
endpackage

// File: rtl/vic_lvt_src.sv
module vic_lvt_src
   import vic_pkg::*;
#(
   parameter bit FORCE_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  lvt_t cfg,
   output logic set_edge,
   output logic set_lvl,
   output logic ext_req
);
   logic prev;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= line;
   end

   generate
      if (FORCE_EDGE) begin : g_edge_only
         logic cfg_unused;
         assign cfg_unused = cfg.level ^ (^cfg.mode) ^ (^cfg.vec);
         assign set_edge   = !cfg.mask && line && !prev;
         assign set_lvl    = 1'b0;
         assign ext_req    = 1'b0;
      end else begin : g_full
         logic is_ext;
         logic vec_unused;
         assign vec_unused = ^cfg.vec;
         assign is_ext   = (cfg.mode == DM_EXT);
         assign set_edge = !cfg.mask && !is_ext && !cfg.level && line && !prev;
         assign set_lvl  = !cfg.mask && !is_ext && cfg.level && line;
         assign ext_req  = !cfg.mask && is_ext && line;
      end
   endgenerate

   // R11
   edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_edge |=> !set_edge);
endmodule

// File: rtl/vic_vec_core.sv
module vic_vec_core #(
   parameter int VEC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [(1<<VEC_W)-1:0]   set_edge,
   input  logic [(1<<VEC_W)-1:0]   set_lvl,
   input  logic                    sw_en,
   input  logic [3:0]              tpr_cls,
   input  logic [VEC_W-1:0]        spur_vec,
   input  logic                    irq_ack,
   input  logic                    eoi,
   output logic                    irq_req,
   output logic [VEC_W-1:0]        irq_vector,
   output logic                    ack_valid,
   output logic [VEC_W-1:0]        ack_vector
);
   localparam int NVEC  = 1 << VEC_W;
   localparam int CLS_W = 4;
   localparam logic [NVEC-1:0] ONE = NVEC'(1);

   generate
      if (VEC_W < CLS_W + 1) begin : g_bad_width
         $error("vic_vec_core: VEC_W too small for a priority class field");
      end
   endgenerate

   logic [NVEC-1:0]  pend, isr, pend_n, isr_n, take_oh, eoi_oh;
   logic [VEC_W-1:0] top_p, top_i;
   logic             any_p, any_i, eligible, take;
   logic [CLS_W-1:0] p_cls, i_cls;

   always_comb begin
      top_p = '0;
      top_i = '0;
      for (int i = 0; i < NVEC; i++) begin
         if (pend[i]) top_p = VEC_W'(i);
         if (isr[i])  top_i = VEC_W'(i);
      end
   end

   assign any_p    = |pend;
   assign any_i    = |isr;
   assign p_cls    = top_p[VEC_W-1 -: CLS_W];
   assign i_cls    = any_i ? top_i[VEC_W-1 -: CLS_W] : '0;
   assign eligible = sw_en && any_p && (p_cls > tpr_cls) && (p_cls > i_cls);
   assign take     = irq_ack && eligible;
   assign take_oh  = take ? (ONE << top_p) : '0;
   assign eoi_oh   = (eoi && any_i) ? (ONE << top_i) : '0;
   assign pend_n   = (pend & ~take_oh) | set_edge | (set_lvl & ~isr & ~take_oh);
   assign isr_n    = (isr & ~eoi_oh) | take_oh;

   assign irq_req    = eligible;
   assign irq_vector = eligible ? top_p : spur_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend       <= '0;
         isr        <= '0;
         ack_valid  <= 1'b0;
         ack_vector <= '0;
      end else begin
         pend      <= pend_n;
         isr       <= isr_n;
         ack_valid <= irq_ack;
         if (irq_ack) ack_vector <= irq_vector;
      end
   end

   // R7
   spur_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !eligible && !eoi) |=> (isr == $past(isr)));
   // R8
   eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && any_i && !irq_ack) |=> ($countones(isr) == $past($countones(isr)) - 1));
   // R5
   nest_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !eoi) |=> (top_i == $past(top_p)));
   // R6
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(irq_ack));
endmodule

// File: rtl/vec_irq_core.sv
module vec_irq_core
   import vic_pkg::*;
#(
   parameter int          ADDR_W        = 12,
   parameter int          DATA_W        = 32,
   parameter int          ILLEGAL_BELOW = 16,
   parameter logic [7:0]  SPUR_RESET    = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              msg_valid,
   input  logic [7:0]        msg_vector,
   input  logic              timer_tick,
   input  logic              local_in0,
   input  logic              local_in1,
   output logic              irq_req,
   output logic [7:0]        irq_vector,
   input  logic              irq_ack,
   output logic              ack_valid,
   output logic [7:0]        ack_vector,
   output logic              ext_intr
);
   localparam int VEC_W = 8;
   localparam int NVEC  = 1 << VEC_W;
   localparam logic [VEC_W-1:0] MIN_V = VEC_W'(ILLEGAL_BELOW);

   generate
      if (ADDR_W < 10) begin : g_bad_addr
         $error("vec_irq_core: ADDR_W cannot reach the register offsets");
      end
      if (DATA_W < 32) begin : g_bad_data
         $error("vec_irq_core: DATA_W must be at least 32");
      end
      if (ILLEGAL_BELOW < 1 || ILLEGAL_BELOW > 255) begin : g_bad_min
         $error("vec_irq_core: ILLEGAL_BELOW out of range");
      end
   endgenerate

   logic [7:0]  tpr;
   logic        sw_en;
   logic [7:0]  spur;
   logic [3:0]  dfr_model;
   logic [7:0]  err_acc, esr_vis, err_new;
   lvt_t        lvt [NUM_SRC];
   logic        msg_bad;
   logic [NUM_SRC-1:0] src_line, src_edge, src_lvl, src_ext;
   logic [NVEC-1:0]    set_e, set_l;
   logic        eoi_wr, esr_wr;
   logic        wdata_unused;

   assign wdata_unused = ^reg_wdata;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign eoi_wr  = reg_wr && hit(reg_addr, OFS_EOI);
   assign esr_wr  = reg_wr && hit(reg_addr, OFS_ESR);
   assign msg_bad = msg_valid && (msg_vector < MIN_V);
   assign err_new = msg_bad ? (8'd1 << ERR_RX_BIT) : 8'd0;

   // register file
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tpr       <= '0;
         sw_en     <= 1'b0;
         spur      <= SPUR_RESET;
         dfr_model <= 4'hF;
         err_acc   <= '0;
         esr_vis   <= '0;
      end else begin
         if (reg_wr && hit(reg_addr, OFS_TPR)) tpr <= reg_wdata[7:0];
         if (reg_wr && hit(reg_addr, OFS_SVR)) begin
            sw_en <= reg_wdata[8];
            spur  <= reg_wdata[7:0];
         end
         if (reg_wr && hit(reg_addr, OFS_DFR)) dfr_model <= reg_wdata[31:28];
         if (esr_wr) begin
            esr_vis <= err_acc;
            err_acc <= err_new;
         end else begin
            err_acc <= err_acc | err_new;
         end
      end
   end

   // local entries and their sources
   assign src_line[SRC_TMR] = timer_tick;
   assign src_line[SRC_L0]  = local_in0;
   assign src_line[SRC_L1]  = local_in1;
   assign src_line[SRC_ERR] = |err_new;

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lvt[s] <= LVT_RESET;
            end else if (reg_wr && hit(reg_addr, lvt_offset(s))) begin
               lvt[s] <= '{mask: reg_wdata[16], level: reg_wdata[15],
                           mode: reg_wdata[10:8], vec: reg_wdata[7:0]};
            end
         end

         vic_lvt_src #(
            .FORCE_EDGE((s == SRC_TMR) || (s == SRC_ERR))
         ) u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .line     (src_line[s]),
            .cfg      (lvt[s]),
            .set_edge (src_edge[s]),
            .set_lvl  (src_lvl[s]),
            .ext_req  (src_ext[s])
         );
      end
   endgenerate

   always_comb begin
      set_e = '0;
      set_l = '0;
      if (msg_valid && !msg_bad) set_e[msg_vector] = 1'b1;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (src_edge[s] && lvt[s].vec >= MIN_V) set_e[lvt[s].vec] = 1'b1;
         if (src_lvl[s]  && lvt[s].vec >= MIN_V) set_l[lvt[s].vec] = 1'b1;
      end
   end

   assign ext_intr = sw_en && (|src_ext);

   vic_vec_core #(.VEC_W(VEC_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_edge   (set_e),
      .set_lvl    (set_l),
      .sw_en      (sw_en),
      .tpr_cls    (tpr[7:4]),
      .spur_vec   (spur),
      .irq_ack    (irq_ack),
      .eoi        (eoi_wr),
      .irq_req    (irq_req),
      .irq_vector (irq_vector),
      .ack_valid  (ack_valid),
      .ack_vector (ack_vector)
   );

   // read mux
   function automatic logic [31:0] lvt_word(input lvt_t e);
      return {15'd0, e.mask, e.level, 4'd0, e.mode, e.vec};
   endfunction

   always_comb begin
      reg_rdata = '0;
      if (hit(reg_addr, OFS_TPR))     reg_rdata = DATA_W'(tpr);
      if (hit(reg_addr, OFS_SVR))     reg_rdata = DATA_W'({sw_en, spur});
      if (hit(reg_addr, OFS_DFR))     reg_rdata = DATA_W'({dfr_model, 28'hFFF_FFFF});
      if (hit(reg_addr, OFS_ESR))     reg_rdata = DATA_W'(esr_vis);
      for (int s = 0; s < NUM_SRC; s++) begin
         if (hit(reg_addr, lvt_offset(s))) reg_rdata = DATA_W'(lvt_word(lvt[s]));
      end
   end

   // R2
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |-> (!irq_req && !ext_intr));
   // R9
   esr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (esr_wr && !msg_bad) |=> (err_acc == '0));
endmodule

// File: tb/vec_irq_core_bench.sv
module vec_irq_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        msg_valid = 1'b0;
   logic [7:0]  msg_vector = '0;
   logic        timer_tick = 1'b0, local_in0 = 1'b0, local_in1 = 1'b0;
   logic        irq_req, ack_valid, ext_intr;
   logic [7:0]  irq_vector, ack_vector;
   logic        irq_ack = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   vec_irq_core u_vec_irq_core (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
      .msg_vector(msg_vector), .timer_tick(timer_tick), .local_in0(local_in0),
      .local_in1(local_in1), .irq_req(irq_req), .irq_vector(irq_vector),
      .irq_ack(irq_ack), .ack_valid(ack_valid), .ack_vector(ack_vector),
      .ext_intr(ext_intr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      timer_tick = 0; local_in0 = 0; local_in1 = 0; msg_valid = 0; irq_ack = 0; reg_wr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic send(input logic [7:0] v);
      @(negedge clk);
      msg_valid = 1'b1; msg_vector = v;
      @(negedge clk);
      msg_valid = 1'b0;
   endtask

   task automatic ack(input string req, input logic [7:0] exp);
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      check(req, {31'd0, ack_valid}, 32'd1);
      check(req, {24'd0, ack_vector}, {24'd0, exp});
   endtask

   task automatic expect_irq(input string req, input logic r, input logic [7:0] v);
      check(req, {31'd0, irq_req}, {31'd0, r});
      if (r) check(req, {24'd0, irq_vector}, {24'd0, v});
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      rd(12'h320, d); check("R1 timer entry", d, 32'h0001_0000);
      rd(12'h350, d); check("R1 local0 entry", d, 32'h0001_0000);
      rd(12'h360, d); check("R1 local1 entry", d, 32'h0001_0000);
      rd(12'h370, d); check("R1 error entry", d, 32'h0001_0000);
      rd(12'h080, d); check("R1 tpr", d, 32'h0);
      rd(12'h0F0, d); check("R1 svr", d, 32'h0FF);
      rd(12'h0E0, d); check("R1 dfr", d, 32'hFFFF_FFFF);
      rd(12'h280, d); check("R1 esr", d, 32'h0);
      check("R1 irq_req", {31'd0, irq_req}, 32'd0);
   endtask

   task automatic t_enable();
      do_reset();
      wr(12'h0F0, 32'h04F);
      send(8'h40);
      expect_irq("R2 disabled", 1'b0, 8'h00);
      check("R2 spurious shown", {24'd0, irq_vector}, 32'h4F);
      ack("R2 ack while disabled", 8'h4F);
      wr(12'h0F0, 32'h14F);
      expect_irq("R2 enabled later", 1'b1, 8'h40);
   endtask

   task automatic t_order();
      do_reset();
      wr(12'h0F0, 32'h1FF);
      send(8'h35); send(8'h72); send(8'h50);
      expect_irq("R3 highest vector", 1'b1, 8'h72);
   endtask

   task automatic t_tpr();
      do_reset();
      wr(12'h0F0, 32'h1FF);
      wr(12'h080, 32'h70);
      send(8'h72);
      expect_irq("R4 same class blocked", 1'b0, 8'h00);
      send(8'h85);
      expect_irq("R4 higher class passes", 1'b1, 8'h85);
   endtask

   task automatic t_nest_eoi();
      do_reset();
      wr(12'h0F0, 32'h1FF);
      send(8'h85);
      ack("R6 first ack", 8'h85);
      expect_irq("R6 pending cleared", 1'b0, 8'h00);
      send(8'h91);
      expect_irq("R5 higher class nests", 1'b1, 8'h91);
      ack("R6 nested ack", 8'h91);
      send(8'h8A);
      expect_irq("R5 blocked by in-service", 1'b0, 8'h00);
      wr(12'h0B0, 32'h0);
      expect_irq("R8 one eoi still blocks", 1'b0, 8'h00);
      wr(12'h0B0, 32'h0);
      expect_irq("R8 second eoi releases", 1'b1, 8'h8A);
   endtask

   task automatic t_spurious();
      do_reset();
      wr(12'h0F0, 32'h1FF);
      ack("R7 spurious ack", 8'hFF);
      send(8'h30);
      expect_irq("R7 no in-service left", 1'b1, 8'h30);
   endtask

   task automatic t_errors();
      logic [31:0] d;
      do_reset();
      wr(12'h0F0, 32'h1FF);
      wr(12'h370, 32'h0000_00E0);
      send(8'h0C);
      rd(12'h280, d); check("R9 hidden before latch", d, 32'h0);
      expect_irq("R10 error vector pends", 1'b1, 8'hE0);
      wr(12'h280, 32'h1234);
      rd(12'h280, d); check("R9 latched", d, 32'h40);
      wr(12'h280, 32'h0);
      rd(12'h280, d); check("R9 cleared", d, 32'h0);
      ack("R10 error ack", 8'hE0);
      wr(12'h0B0, 32'h0);
      expect_irq("R9 illegal vector dropped", 1'b0, 8'h00);
   endtask

   task automatic t_local();
      do_reset();
      wr(12'h0F0, 32'h1FF);
      local_in0 = 1'b1;
      repeat (2) @(negedge clk);
      expect_irq("R11 masked line ignored", 1'b0, 8'h00);
      local_in0 = 1'b0;
      wr(12'h350, 32'h0000_0060);
      local_in0 = 1'b1;
      @(negedge clk);
      expect_irq("R11 edge pends", 1'b1, 8'h60);
      ack("R11 edge ack", 8'h60);
      wr(12'h0B0, 32'h0);
      repeat (2) @(negedge clk);
      expect_irq("R11 edge held no repeat", 1'b0, 8'h00);
      local_in0 = 1'b0;
      wr(12'h350, 32'h0000_8061);
      local_in0 = 1'b1;
      @(negedge clk);
      ack("R11 level ack", 8'h61);
      wr(12'h0B0, 32'h0);
      repeat (2) @(negedge clk);
      expect_irq("R11 level re-pends", 1'b1, 8'h61);
      local_in0 = 1'b0;
   endtask

   task automatic t_ext_timer();
      do_reset();
      wr(12'h0F0, 32'h1FF);
      wr(12'h360, 32'h0000_0770);
      local_in1 = 1'b1;
      #1;
      check("R12 ext follows line", {31'd0, ext_intr}, 32'd1);
      @(negedge clk);
      expect_irq("R12 nothing pends", 1'b0, 8'h00);
      local_in1 = 1'b0;
      #1;
      check("R12 ext drops", {31'd0, ext_intr}, 32'd0);
      wr(12'h320, 32'h0000_8080);
      timer_tick = 1'b1;
      @(negedge clk);
      ack("R13 timer ack", 8'h80);
      wr(12'h0B0, 32'h0);
      repeat (2) @(negedge clk);
      expect_irq("R13 timer stays edge", 1'b0, 8'h00);
      timer_tick = 1'b0;
   endtask

   task automatic t_dfr();
      logic [31:0] d;
      do_reset();
      wr(12'h0E0, 32'h0000_0000);
      rd(12'h0E0, d); check("R14 model cleared", d, 32'h0FFF_FFFF);
      wr(12'h0E0, 32'hA000_0000);
      rd(12'h0E0, d); check("R14 model stored", d, 32'hAFFF_FFFF);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_enable();
      t_order();
      t_tpr();
      t_nest_eoi();
      t_spurious();
      t_errors();
      t_local();
      t_ext_timer();
      t_dfr();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule